// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Selector

This block is the digital counter chain of a crystal-referenced frequency synthesizer. Every part runs on one fast system clock. The three slow clocks reach the block as one-cycle strobes. The first marks a crystal period. The second marks each transition (rise or fall) of a stand-in VCO. The third marks a rising edge of the serial configuration clock. A fixed prescaler divides the crystal by sixteen to make the reference square wave. A programmable divider counts VCO rising edges and produces the feedback signal. An output divider makes a 50% duty output at the VCO rate divided by 1, 2, 4 or 8.

A 3-bit test code steers one of eight sources onto a single observation pin. The sources are the serial shift-register output, constant high or low, the reference, the halved feedback divider, the output, the output divided by four, and a second copy of the programmable divider that counts serial-clock edges. The configuration block supplies the divider values and the test code. The phase detector and the loop itself lie outside this block.

Top module: `synth_div_chain`

## Requirements
- R1: While reset is asserted, and until the first strobe after it, ref_clk, fb_clk and fout are 0. With test code 001, test_out is 1 during reset.
- R2: ref_clk is 1 when the number of crystal strobes since reset, taken modulo 16, is 8 to 15. It is 0 otherwise, so it has period 16 strobes and a 50% duty cycle.
- R3: A VCO rising edge is a VCO strobe seen while the VCO edge count since reset is even. The first rising edge after reset is terminal. After that, a terminal edge comes every M rising edges, and M of 0 or 1 makes every rising edge terminal. fb_clk is 1 from a terminal rising edge until the next rising edge.
- R4: m_val is sampled only on a terminal rising edge, where it sets the length of the following period. A change at any other time has no effect on the current period.
- R5: fout equals bit k of the VCO edge count modulo 64, where k is the latched output select. Select values 00, 01, 10 and 11 give division by 1, 2, 4 and 8 with a 50% duty cycle.
- R6: The latched output select is 00 after reset. It takes n_sel only on a VCO strobe that moves the low four bits of the edge count from 15 to 0.
- R7: test_out follows shift_out for code 000, is 1 for code 001, and is 0 for code 101.
- R8: Code 010 shows ref_clk, and code 100 shows fout. Code 011 shows a level that toggles on each terminal VCO rising edge, which is the feedback division further halved.
- R9: Code 111 shows bit k+2 of the VCO edge count, which is fout divided by four.
- R10: Code 110 shows the terminal level of a second M divider. This divider counts serial-clock strobes under the rules of R3 and R4, using the same m_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | One-cycle strobe per crystal period |
| vco_edge | input | 1 | One-cycle strobe per VCO transition |
| sclk_rise | input | 1 | One-cycle strobe per serial-clock rising edge |
| m_val | input | 9 | Feedback division ratio |
| n_sel | input | 2 | Output division select (ratio 2^n_sel) |
| t_code | input | 3 | Test selector code |
| shift_out | input | 1 | Serial shift-register output from the configuration block |
| ref_clk | output | 1 | Crystal divided by 16 |
| fb_clk | output | 1 | Feedback divider terminal level |
| fout | output | 1 | Divided synthesizer output |
| test_out | output | 1 | Test observation pin |

## Verification
The feedback divider can reach its terminal edge in the same cycle that m_val changes. The output divider can wrap in the same cycle that n_sel changes. In both cases the only correct result is that the old period completes and the new value governs the next one. The bench changes m_val and n_sel at random on a dense schedule, so that both kinds of coincidence occur many times. These include M values of 0, 1, 2 and 511. A behavioural model written with integers is compared with every output on every clock, so a value picked up one cycle early or late shows up as a mismatch on fb_clk, fout or test_out.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int REF_RATIO = 16;
  localparam int M_W       = 9;
  localparam int N_W       = 2;

  typedef enum logic [2:0] {
    TSEL_SHIFT  = 3'b000,
    TSEL_HIGH   = 3'b001,
    TSEL_REF    = 3'b010,
    TSEL_FBHALF = 3'b011,
    TSEL_FOUT   = 3'b100,
    TSEL_LOW    = 3'b101,
    TSEL_SCLKM  = 3'b110,
    TSEL_FOUT4  = 3'b111
  } tsel_e;
endpackage

// File: rtl/sdc_ref_prescaler.sv
module sdc_ref_prescaler #(
  parameter int RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic ref_clk
);
  localparam int W = $clog2(RATIO);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q == W'(RATIO - 1)) cnt_d = '0;
      else                        cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // upper half of the count is the high phase
  assign ref_clk = (cnt_q >= W'(RATIO / 2));
endmodule

// File: rtl/sdc_m_divider.sv
module sdc_m_divider #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] m_val,
  output logic         term,
  output logic         half
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         term_q, term_d;
  logic         half_q, half_d;

  // down counter; ratio is reloaded only at terminal count
  always_comb begin
    cnt_d  = cnt_q;
    term_d = term_q;
    half_d = half_q;
    if (tick) begin
      if (cnt_q <= W'(1)) begin
        cnt_d  = m_val;
        term_d = 1'b1;
        half_d = ~half_q;
      end else begin
        cnt_d  = cnt_q - W'(1);
        term_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      term_q <= term_d;
      half_q <= half_d;
    end
  end

  assign term = term_q;
  assign half = half_q;
endmodule

// File: rtl/sdc_out_divider.sv
module sdc_out_divider #(
  parameter int N_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           edge_tick,
  input  logic [N_W-1:0] n_sel,
  output logic           vco_lvl,
  output logic           fout,
  output logic           fout_q4,
  output logic [N_W-1:0] n_lat,
  output logic           at_wrap
);
  localparam int MAXSEL = (1 << N_W) - 1;
  localparam int WRAP_W = MAXSEL + 1;
  localparam int CW     = MAXSEL + 3;
  localparam int IDX_W  = $clog2(CW);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [N_W-1:0]   nl_q, nl_d;
  logic [IDX_W-1:0] tap_i, tap4_i;
  logic             wrap_w;

  assign wrap_w = (cnt_q[WRAP_W-1:0] == {WRAP_W{1'b1}});

  always_comb begin
    cnt_d = cnt_q;
    nl_d  = nl_q;
    if (edge_tick) begin
      cnt_d = cnt_q + CW'(1);
      if (wrap_w) nl_d = n_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      nl_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      nl_q  <= nl_d;
    end
  end

  assign tap_i   = IDX_W'(nl_q);
  assign tap4_i  = tap_i + IDX_W'(2);
  assign vco_lvl = cnt_q[0];
  assign fout    = cnt_q[tap_i];
  assign fout_q4 = cnt_q[tap4_i];
  assign n_lat   = nl_q;
  assign at_wrap = wrap_w;
endmodule

// File: rtl/sdc_test_mux.sv
module sdc_test_mux
  import sdc_pkg::*;
(
  input  logic [2:0] t_code,
  input  logic       shift_out,
  input  logic       ref_clk,
  input  logic       fb_half,
  input  logic       fout,
  input  logic       sclk_term,
  input  logic       fout_q4,
  output logic       test_out
);
  tsel_e sel;

  assign sel = tsel_e'(t_code);

  always_comb begin
    unique case (sel)
      TSEL_SHIFT:  test_out = shift_out;
      TSEL_HIGH:   test_out = 1'b1;
      TSEL_REF:    test_out = ref_clk;
      TSEL_FBHALF: test_out = fb_half;
      TSEL_FOUT:   test_out = fout;
      TSEL_LOW:    test_out = 1'b0;
      TSEL_SCLKM:  test_out = sclk_term;
      TSEL_FOUT4:  test_out = fout_q4;
      default:     test_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
  import sdc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xtal_tick,
  input  logic           vco_edge,
  input  logic           sclk_rise,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_sel,
  input  logic [2:0]     t_code,
  input  logic           shift_out,
  output logic           ref_clk,
  output logic           fb_clk,
  output logic           fout,
  output logic           test_out
);
  logic [1:0]     rst_sync_q;
  logic           core_rst_n;
  logic           vco_lvl, vco_rise;
  logic           fb_half, sclk_term, sclk_half, fout_q4;
  logic [N_W-1:0] n_lat_w;
  logic           at_wrap_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  sdc_ref_prescaler #(.RATIO(REF_RATIO)) u_ref (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .tick    (xtal_tick),
    .ref_clk (ref_clk)
  );

  sdc_out_divider #(.N_W(N_W)) u_out (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .edge_tick (vco_edge),
    .n_sel     (n_sel),
    .vco_lvl   (vco_lvl),
    .fout      (fout),
    .fout_q4   (fout_q4),
    .n_lat     (n_lat_w),
    .at_wrap   (at_wrap_w)
  );

  assign vco_rise = vco_edge & ~vco_lvl;

  sdc_m_divider #(.W(M_W)) u_fb (
    .clk   (clk),
    .rst_n (core_rst_n),
    .tick  (vco_rise),
    .m_val (m_val),
    .term  (fb_clk),
    .half  (fb_half)
  );

  sdc_m_divider #(.W(M_W)) u_sclk (
    .clk   (clk),
    .rst_n (core_rst_n),
    .tick  (sclk_rise),
    .m_val (m_val),
    .term  (sclk_term),
    .half  (sclk_half)
  );

  sdc_test_mux u_mux (
    .t_code    (t_code),
    .shift_out (shift_out),
    .ref_clk   (ref_clk),
    .fb_half   (fb_half),
    .fout      (fout),
    .sclk_term (sclk_term),
    .fout_q4   (fout_q4),
    .test_out  (test_out)
  );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       xtal_tick,
  input logic       vco_edge,
  input logic       sclk_rise,
  input logic [2:0] t_code,
  input logic       ref_clk,
  input logic       fb_clk,
  input logic       fout,
  input logic       test_out,
  input logic [1:0] n_lat,
  input logic       at_wrap
);
  AST_REF_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_clk) |-> $past(xtal_tick)); // R2

  AST_FB_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_clk) |-> $past(vco_edge)); // R3

  AST_FOUT_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fout) |-> $past(vco_edge)); // R5

  AST_NSEL_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_lat) |-> ($past(vco_edge) && $past(at_wrap))); // R6

  AST_TEST_HIGH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b001) |-> test_out); // R7

  AST_TEST_LOW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b101) |-> !test_out); // R7

  AST_SCLK_PATH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b110 && $past(t_code) == 3'b110 && !$past(sclk_rise))
      |-> $stable(test_out)); // R10
endmodule

bind synth_div_chain sdc_checker u_sdc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .xtal_tick (xtal_tick),
  .vco_edge  (vco_edge),
  .sclk_rise (sclk_rise),
  .t_code    (t_code),
  .ref_clk   (ref_clk),
  .fb_clk    (fb_clk),
  .fout      (fout),
  .test_out  (test_out),
  .n_lat     (n_lat_w),
  .at_wrap   (at_wrap_w)
);

// File: tb/synth_div_chain_test.sv
`timescale 1ns/1ps
module synth_div_chain_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       xtal_tick, vco_edge, sclk_rise, shift_out;
  logic [8:0] m_val;
  logic [1:0] n_sel;
  logic [2:0] t_code;
  logic       ref_clk, fb_clk, fout, test_out;

  always #2 clk = ~clk;

  synth_div_chain uut (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .vco_edge(vco_edge),
    .sclk_rise(sclk_rise), .m_val(m_val), .n_sel(n_sel), .t_code(t_code),
    .shift_out(shift_out), .ref_clk(ref_clk), .fb_clk(fb_clk), .fout(fout),
    .test_out(test_out)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural reference state
  int ref_n, edges, nl, vm_rem, sm_rem;
  bit v_term, v_half, s_term;

  task automatic check(string req, string phase, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] %s actual=%0b expected=%0b", req, phase, what, act, exp);
    end
  endtask

  task automatic model_reset();
    ref_n = 0; edges = 0; nl = 0; vm_rem = 0; sm_rem = 0;
    v_term = 0; v_half = 0; s_term = 0;
  endtask

  // apply the inputs that were present at the last rising edge
  task automatic model_step();
    bit rise;
    if (xtal_tick) ref_n = (ref_n + 1) % 16;
    if (vco_edge) begin
      rise = (edges % 2) == 0;
      if ((edges % 16) == 15) nl = n_sel;
      edges = (edges + 1) % 64;
      if (rise) begin
        if (vm_rem <= 1) begin vm_rem = m_val; v_term = 1; v_half = !v_half; end
        else begin vm_rem = vm_rem - 1; v_term = 0; end
      end
    end
    if (sclk_rise) begin
      if (sm_rem <= 1) begin sm_rem = m_val; s_term = 1; end
      else begin sm_rem = sm_rem - 1; s_term = 0; end
    end
  endtask

  function automatic logic exp_fout(int shift);
    return logic'((edges >> (nl + shift)) & 1);
  endfunction

  function automatic logic exp_test();
    case (t_code)
      3'd0: return shift_out;
      3'd1: return 1'b1;
      3'd2: return logic'(ref_n >= 8);
      3'd3: return v_half;
      3'd4: return exp_fout(0);
      3'd5: return 1'b0;
      3'd6: return s_term;
      default: return exp_fout(2);
    endcase
  endfunction

  function automatic string test_req();
    case (t_code)
      3'd0, 3'd1, 3'd5: return "R7";
      3'd2, 3'd3, 3'd4: return "R8";
      3'd6: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic compare_all(string phase);
    check("R2", phase, "ref_clk", ref_clk, logic'(ref_n >= 8));
    check("R3", phase, "fb_clk", fb_clk, v_term);
    check("R5", phase, "fout", fout, exp_fout(0));
    check(test_req(), phase, "test_out", test_out, exp_test());
  endtask

  task automatic run_phase(string phase, int cycles, int m_chg, int n_chg, int m_kind);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      model_step();
      compare_all(phase);
      xtal_tick = ($urandom % 3) == 0;
      vco_edge  = ($urandom % 2) == 0;
      sclk_rise = ($urandom % 4) == 0;
      shift_out = $urandom % 2;
      if (($urandom % m_chg) == 0) begin
        case (m_kind)
          0: m_val = 9'(3 + $urandom % 10);
          1: m_val = 9'($urandom % 21);
          default: case ($urandom % 4)
                     0: m_val = 9'd0;
                     1: m_val = 9'd1;
                     2: m_val = 9'd2;
                     default: m_val = 9'd511;
                   endcase
        endcase
      end
      if (($urandom % n_chg) == 0) n_sel = 2'($urandom % 4);
      if ((c % 150) == 149) t_code = t_code + 3'd1;
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; xtal_tick = 0; vco_edge = 0; sclk_rise = 0; shift_out = 0;
    m_val = 9'd5; n_sel = 2'd0; t_code = 3'b001;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset", "ref_clk", ref_clk, 1'b0);
    check("R1", "reset", "fb_clk", fb_clk, 1'b0);
    check("R1", "reset", "fout", fout, 1'b0);
    check("R1", "reset", "test_out code 001", test_out, 1'b1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", "after release", "fout", fout, 1'b0);
    check("R1", "after release", "fb_clk", fb_clk, 1'b0);
    t_code = 3'b000; shift_out = 1;
    @(negedge clk);
    check("R7", "shift path", "test_out", test_out, 1'b1);
    shift_out = 0; t_code = 3'b101;
    @(negedge clk);
    check("R7", "low code", "test_out", test_out, 1'b0);
    t_code = 3'b010;

    run_phase("R2 R3 R5 base", 6000, 40, 60, 0);
    run_phase("R4 M reload", 8000, 4, 60, 1);
    run_phase("R6 N wrap", 8000, 40, 3, 0);
    run_phase("R3 R10 M limits", 12000, 300, 20, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule